// File: doc/BRIEF.md
# Audio DMA Control and Interrupt Register Block

This block holds the control and interrupt state for a three-channel audio DMA engine: two playback channels and one capture channel. Software reaches it through a simple word-addressed read/write bus. A 16-bit control register drives the engine's enable outputs. These are a core reset (active low), the audio port pin enable, the I2C unit enable and one transfer enable per DMA channel.

A control write carries two halves. The upper halfword is a per-bit write mask and the lower halfword holds the new values. Only the bits selected by the mask change, so software can set or clear one enable without a read-modify-write.

Five event pulses feed an interrupt status register whose bits software clears by writing 1. The events are end-of-range from each DMA channel plus a status event and an error event from the I2C unit. An interrupt enable register chooses which status bits drive the single interrupt line.

Top module: `audio_dma_regs`

## Requirements
- R1: A write to word address 0 changes control bit n (n = 0..15) only when bit n+16 of the written word is 1. A control bit whose mask bit is 0 keeps its value.
- R2: A control bit whose mask bit is 1 takes bit n of the written word. A mask bit of 1 with a data bit of 0 clears the control bit.
- R3: The control register drives outputs directly. Bit 0 drives `core_rst_n`, bit 1 `port_pins_en`, bit 2 `i2c_en`, bit 3 `xfer_en[0]` (playback 1), bit 4 `xfer_en[1]` (playback 2) and bit 5 `xfer_en[2]` (capture 1). Each output follows its bit from the clock edge that captures the write.
- R4: A read of word address 0 returns the 16 control bits in `rd_data[15:0]` and zeros in `rd_data[31:16]`.
- R5: Word address 1 is the interrupt enable register. Bits [4:0] are written directly and read back zero-extended. Writing zero masks every source, so `irq` stays low whatever the status.
- R6: Word address 2 reads the interrupt status register. Bit 0 is playback-1 end, bit 1 playback-2 end, bit 2 capture-1 end, bit 3 I2C status and bit 4 I2C error. A one-cycle event pulse sets its bit at the next edge, whether or not the bit is enabled.
- R7: Writing word address 2 clears each status bit whose data bit is 1 and leaves the bits written 0 alone. Writing back the value just read clears exactly the bits that were set.
- R8: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is the OR over all sources of status AND enable, and it is decoded from the registered state.
- R10: After reset all control, enable and status bits are 0, so `core_rst_n` is low and `irq` is low.
- R11: Writes to word address 3 change no state, and reads from it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Word address |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_play1_end | input | 1 | Playback channel 1 end-of-range pulse |
| evt_play2_end | input | 1 | Playback channel 2 end-of-range pulse |
| evt_cap1_end | input | 1 | Capture channel 1 end-of-range pulse |
| evt_i2c_stat | input | 1 | I2C status event pulse |
| evt_i2c_err | input | 1 | I2C error event pulse |
| core_rst_n | output | 1 | Engine reset, active low |
| port_pins_en | output | 1 | Audio port pin enable |
| i2c_en | output | 1 | I2C unit enable |
| xfer_en | output | 3 | Per-channel transfer enables |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets four failure modes.

- Mask without data. A control write with all mask bits clear must not disturb anything. A design that ignored the upper halfword would overwrite the register with the data bits.
- Clearing bit 0 alone. A mask-only write must clear the core reset bit and no other. A design that OR-ed the data in would never clear it.
- Clear colliding with an event. When a write-1-to-clear meets a new event on the same bit, the bit must stay set. A design that gave the clear priority would lose that interrupt.
- Unmapped address and masked interrupts. A write to the spare address must change nothing, and disabled sources must keep `irq` low. A decoder that aliased addresses, or a line that ignored the enables, would show up as corrupted readback or a spurious `irq`.

// File: rtl/audreg_pkg.sv
package audreg_pkg;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned CTRL_W  = BUS_W / 2;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned NUM_CH  = 3;

  // word addresses
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 2'd1;
  localparam logic [ADDR_W-1:0] A_ISTAT = 2'd2;

  // control bit positions
  localparam int unsigned CB_CORE_RSTN = 0;
  localparam int unsigned CB_PORT_EN   = 1;
  localparam int unsigned CB_I2C_EN    = 2;
  localparam int unsigned CB_XFER0     = 3;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_IEN,
    SEL_ISTAT,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/audreg_ctrl.sv
module audreg_ctrl #(
  parameter int unsigned CTRL_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2*CTRL_W-1:0] wr_word,
  output logic [CTRL_W-1:0]   ctrl_q
);

  localparam int unsigned WORD_W = 2 * CTRL_W;

  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = wr_en & wr_word[CTRL_W + b];
      bit_d  = wr_word[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign ctrl_q[b] = bit_q;
  end

  logic [CTRL_W-1:0] wr_mask;
  logic [CTRL_W-1:0] wr_val;
  assign wr_mask = wr_word[WORD_W-1:CTRL_W];
  assign wr_val  = wr_word[CTRL_W-1:0];

  assert_masked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_q & ~$past(wr_mask)) == ($past(ctrl_q) & ~$past(wr_mask))));

  assert_masked_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_q & $past(wr_mask)) == ($past(wr_val) & $past(wr_mask))));

  assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/audreg_irq.sv
module audreg_irq #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               ien_wr,
  input  logic [NUM_SRC-1:0] ien_wdata,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_wdata,
  output logic [NUM_SRC-1:0] ien_q,
  output logic [NUM_SRC-1:0] stat_q,
  output logic               irq
);

  logic [NUM_SRC-1:0] stat_d;
  logic [NUM_SRC-1:0] clr_mask;

  always_comb begin
    clr_mask = clr_wr ? clr_wdata : '0;
    stat_d   = (stat_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (ien_wr) begin
      ien_q <= ien_wdata;
    end
  end

  assign irq = |(stat_q & ien_q);

  assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

  assert_evt_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((evt & clr_wdata) != '0)) |=> ((stat_q & $past(evt & clr_wdata)) == $past(evt & clr_wdata)));

  assert_clear_only_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && evt == '0) |=> (stat_q == ($past(stat_q) & ~$past(clr_wdata))));

  assert_quiet_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && evt == '0) |=> $stable(stat_q));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

endmodule

// File: rtl/audio_dma_regs.sv
module audio_dma_regs
  import audreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              evt_play1_end,
  input  logic              evt_play2_end,
  input  logic              evt_cap1_end,
  input  logic              evt_i2c_stat,
  input  logic              evt_i2c_err,
  output logic              core_rst_n,
  output logic              port_pins_en,
  output logic              i2c_en,
  output logic [NUM_CH-1:0] xfer_en,
  output logic              irq
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // address decode
  reg_sel_e sel;

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  sel = SEL_CTRL;
      A_IEN:   sel = SEL_IEN;
      A_ISTAT: sel = SEL_ISTAT;
      default: sel = SEL_NONE;
    endcase
  end

  logic ctrl_wr;
  logic ien_wr;
  logic clr_wr;

  always_comb begin
    ctrl_wr = bus_we && (sel == SEL_CTRL);
    ien_wr  = bus_we && (sel == SEL_IEN);
    clr_wr  = bus_we && (sel == SEL_ISTAT);
  end

  logic [CTRL_W-1:0] ctrl_q;

  audreg_ctrl #(
    .CTRL_W (CTRL_W)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (ctrl_wr),
    .wr_word (bus_wdata),
    .ctrl_q  (ctrl_q)
  );

  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] ien_q;
  logic [NUM_SRC-1:0] stat_q;

  assign evt_vec = {evt_i2c_err, evt_i2c_stat, evt_cap1_end, evt_play2_end, evt_play1_end};

  audreg_irq #(
    .NUM_SRC (NUM_SRC)
  ) i_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt       (evt_vec),
    .ien_wr    (ien_wr),
    .ien_wdata (bus_wdata[NUM_SRC-1:0]),
    .clr_wr    (clr_wr),
    .clr_wdata (bus_wdata[NUM_SRC-1:0]),
    .ien_q     (ien_q),
    .stat_q    (stat_q),
    .irq       (irq)
  );

  // outputs
  assign core_rst_n   = ctrl_q[CB_CORE_RSTN];
  assign port_pins_en = ctrl_q[CB_PORT_EN];
  assign i2c_en       = ctrl_q[CB_I2C_EN];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_xfer
    assign xfer_en[c] = ctrl_q[CB_XFER0 + c];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_CTRL:  bus_rdata[CTRL_W-1:0]  = ctrl_q;
      SEL_IEN:   bus_rdata[NUM_SRC-1:0] = ien_q;
      SEL_ISTAT: bus_rdata[NUM_SRC-1:0] = stat_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_ctrl_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[BUS_W-1:CTRL_W] == '0));

  assert_spare_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));

  assert_xfer_follows_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_wr && bus_wdata[CTRL_W + CB_XFER0]) |=> (xfer_en[0] == $past(bus_wdata[CB_XFER0])));

endmodule

// File: tb/test_audio_dma_regs.sv
module test_audio_dma_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  evt = '0;
  logic        core_rst_n, port_pins_en, i2c_en, irq;
  logic [2:0]  xfer_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_dma_regs i_audio_dma_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .evt_play1_end (evt[0]),
    .evt_play2_end (evt[1]),
    .evt_cap1_end  (evt[2]),
    .evt_i2c_stat  (evt[3]),
    .evt_i2c_err   (evt[4]),
    .core_rst_n    (core_rst_n),
    .port_pins_en  (port_pins_en),
    .i2c_en        (i2c_en),
    .xfer_en       (xfer_en),
    .irq           (irq)
  );

  // vector: {kind[1:0], addr[1:0], evt[4:0], data[31:0]}
  // kind 0 write, 1 read-compare, 2 event pulse, 3 irq-compare (data[0])
  localparam int NV = 23;
  localparam logic [40:0] VEC [NV] = '{
    {2'd0, 2'd0, 5'h00, 32'h003F_0015},
    {2'd1, 2'd0, 5'h00, 32'h0000_0015},
    {2'd0, 2'd0, 5'h00, 32'h0001_0000},
    {2'd1, 2'd0, 5'h00, 32'h0000_0014},
    {2'd0, 2'd0, 5'h00, 32'h0000_FFFF},
    {2'd1, 2'd0, 5'h00, 32'h0000_0014},
    {2'd0, 2'd0, 5'h00, 32'hFFFF_A5A0},
    {2'd1, 2'd0, 5'h00, 32'h0000_A5A0},
    {2'd2, 2'd0, 5'h1F, 32'h0000_0000},
    {2'd1, 2'd2, 5'h00, 32'h0000_001F},
    {2'd3, 2'd0, 5'h00, 32'h0000_0000},
    {2'd0, 2'd1, 5'h00, 32'hFFFF_FFFF},
    {2'd1, 2'd1, 5'h00, 32'h0000_001F},
    {2'd3, 2'd0, 5'h00, 32'h0000_0001},
    {2'd0, 2'd2, 5'h00, 32'h0000_0005},
    {2'd1, 2'd2, 5'h00, 32'h0000_001A},
    {2'd0, 2'd1, 5'h00, 32'h0000_0001},
    {2'd3, 2'd0, 5'h00, 32'h0000_0000},
    {2'd2, 2'd0, 5'h01, 32'h0000_0000},
    {2'd3, 2'd0, 5'h00, 32'h0000_0001},
    {2'd0, 2'd2, 5'h00, 32'h0000_001B},
    {2'd1, 2'd2, 5'h00, 32'h0000_0000},
    {2'd3, 2'd0, 5'h00, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R10 reset state
    check("R10 core_rst_n", {31'd0, core_rst_n}, 32'd0);
    check("R10 irq", {31'd0, irq}, 32'd0);
    rd_chk("R10 ctrl", 2'd0, 32'd0);
    rd_chk("R10 ien", 2'd1, 32'd0);
    rd_chk("R10 istat", 2'd2, 32'd0);

    // table walk: R1 R2 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [1:0]  a;
      logic [4:0]  e;
      logic [31:0] d;
      {k, a, e, d} = VEC[i];
      case (k)
        2'd0: wr(a, d);
        2'd1: rd_chk("R1/R2/R4/R5/R6/R7 table read", a, d);
        2'd2: pulse(e);
        default: begin
          @(negedge clk);
          check("R9/R5 table irq", {31'd0, irq}, d);
        end
      endcase
    end

    // R3 output mapping
    wr(2'd0, 32'h003F_0029);
    check("R3 outputs", {26'd0, xfer_en, i2c_en, port_pins_en, core_rst_n}, 32'h29);
    wr(2'd0, 32'h0038_0010);
    check("R3 xfer only", {26'd0, xfer_en, i2c_en, port_pins_en, core_rst_n}, 32'h11);

    // R8 event beats clear in the same cycle
    pulse(5'h1F);
    @(negedge clk);
    bus_addr = 2'd2; bus_we = 1'b1; bus_wdata = 32'h1F; evt = 5'h10;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; evt = '0;
    rd_chk("R8 collision", 2'd2, 32'h10);

    // R5 zero enable masks everything
    wr(2'd1, 32'h1F);
    @(negedge clk);
    check("R9 irq from err", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'h0);
    check("R5 masked", {31'd0, irq}, 32'd0);

    // R11 spare address
    rd_chk("R11 read pre", 2'd0, 32'h0000_A591);
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk("R11 spare read", 2'd3, 32'd0);
    rd_chk("R11 ctrl intact", 2'd0, 32'h0000_A591);
    rd_chk("R11 ien intact", 2'd1, 32'd0);
    rd_chk("R11 stat intact", 2'd2, 32'h10);

    // R10 reset mid-run
    do_reset();
    rd_chk("R10 ctrl after rerun", 2'd0, 32'd0);
    rd_chk("R10 istat after rerun", 2'd2, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule